// File: doc/BRIEF.md
# Boot-Mode Program Memory Mapper

This block sits on the core's program-memory request path and decides, every cycle, which of two memories serves a request: a 512-word, 24-bit program RAM or a 32-word boot ROM. In boot mode the program space is split by direction. Every read, at any address, is served by the ROM, and every write lands in the program RAM, which is write-only while code is loaded into it. In any other mode the ROM cannot be reached at all, and the RAM is read and written normally over its address range.

The block holds the operating mode. The mode pins set it while reset is asserted. Software can also write a new mode, for example to end boot or to start a reboot. A written mode does not take effect at once. It is applied after two instruction-slot ticks, which leaves room for one single-cycle instruction and a jump to address 0. A new write during that countdown replaces the pending value and starts the countdown again.

The request side is plain control: one request per cycle, with no back-pressure, because both memories accept a request every cycle. Memory read data returns one cycle after the request. The block marks the returned data with a valid strobe and takes it from whichever memory was selected in the request cycle.

Top module: `boot_pmem_mapper`

## Requirements
- R1: While reset is asserted the mode follows `mode_pins`. After release, `mode_cur` holds that value and `boot_active` is 1 exactly when the mode equals 1.
- R2: In boot mode, a read (`p_valid`=1, `p_write`=0) at any address asserts `rom_rd_en` with `rom_addr` = `p_addr[4:0]` and does not assert `ram_rd_en`.
- R3: In any mode, a write whose address is below 512 asserts `ram_wr_en` with `ram_addr` = `p_addr[8:0]`.
- R4: Outside boot mode, a read below address 512 asserts `ram_rd_en`, and `rom_rd_en` is never asserted.
- R5: A request at address 512 or above asserts no RAM enable in any mode.
- R6: A mode write leaves `mode_cur` unchanged until the second `slot_tick` after it. The new mode appears in the cycle after that tick.
- R7: A mode write during a pending countdown replaces the pending value and restarts the two-tick count.
- R8: When a mode write and a `slot_tick` fall in the same cycle, the tick does not count toward the new countdown.
- R9: An applied write of mode 2 clears `boot_active`. An applied write of mode 1 sets it again (reboot).
- R10: At most one of `ram_rd_en`, `ram_wr_en` and `rom_rd_en` is high in any cycle.
- R11: One cycle after a read enable, `p_rvalid` is 1 and `p_rdata` equals the data input of the memory that was enabled. Otherwise `p_rvalid` is 0 and `p_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pins | input | 2 | Mode value loaded while reset is asserted |
| mode_wr_en | input | 1 | Software mode-register write strobe |
| mode_wr_data | input | 2 | Mode value written by software |
| slot_tick | input | 1 | One pulse per instruction slot |
| p_valid | input | 1 | Program-space request this cycle |
| p_write | input | 1 | Request is a write (1) or a read (0) |
| p_addr | input | 16 | Program-space word address |
| rom_rdata | input | 24 | Boot ROM read data, one cycle after enable |
| ram_rdata | input | 24 | Program RAM read data, one cycle after enable |
| ram_rd_en | output | 1 | Program RAM read enable |
| ram_wr_en | output | 1 | Program RAM write enable |
| ram_addr | output | 9 | Program RAM word address |
| rom_rd_en | output | 1 | Boot ROM read enable |
| rom_addr | output | 5 | Boot ROM word address |
| p_rvalid | output | 1 | Read data valid |
| p_rdata | output | 24 | Read data returned to the core |
| boot_active | output | 1 | Boot mapping in force |
| mode_cur | output | 2 | Operating mode currently applied |

## Verification
Two things can coincide. A mode write can arrive in the same cycle as a slot tick or during a live countdown, and a read issued in the last boot cycle has its data returned after the mapping has already switched. The random stimulus writes modes often and ticks on about one cycle in three, so both overlaps occur many times, and directed sequences force each one explicitly. A bench model of the two-tick rule and of the source registered for each read judges every cycle's mode, enables, addresses and returned data.

// File: rtl/boot_pmem_pkg.sv
package boot_pmem_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_ROM  = 2'd2
  } rd_src_e;

  localparam int MODE_BITS  = 2;
  localparam int BOOT_MODE  = 1;
endpackage

// File: rtl/mode_sequencer.sv
module mode_sequencer #(
  parameter int MODE_W      = 2,
  parameter int DELAY_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              tick,
  output logic [MODE_W-1:0] mode_q
);
  localparam int CNT_W = $clog2(DELAY_SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_SLOTS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [MODE_W-1:0] pend_q;

  // A write always wins over a tick in the same cycle: the countdown restarts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_pins;
      pend_q <= mode_pins;
      cnt_q  <= '0;
    end else if (wr_en) begin
      pend_q <= wr_data;
      cnt_q  <= CNT_LOAD;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_LAST;
      if (cnt_q == CNT_LAST) begin
        mode_q <= pend_q;
      end
    end
  end
endmodule

// File: rtl/access_steer.sv
module access_steer #(
  parameter int ADDR_W    = 16,
  parameter int RAM_DEPTH = 512,
  parameter int ROM_DEPTH = 32
) (
  input  logic                         boot,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         ram_rd,
  output logic                         ram_wr,
  output logic [$clog2(RAM_DEPTH)-1:0] ram_a,
  output logic                         rom_rd,
  output logic [$clog2(ROM_DEPTH)-1:0] rom_a
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam logic [ADDR_W:0] RAM_LIMIT = (ADDR_W+1)'(RAM_DEPTH);

  logic in_ram;
  logic is_rd;
  logic is_wr;

  always_comb begin
    in_ram = ({1'b0, req_addr} < RAM_LIMIT);
    is_rd  = req_valid && !req_write;
    is_wr  = req_valid && req_write;
    ram_a  = req_addr[RAM_AW-1:0];
    rom_a  = req_addr[ROM_AW-1:0];
    // Boot: reads of every address go to ROM (aliasing), writes go to RAM.
    rom_rd = boot && is_rd;
    ram_rd = !boot && is_rd && in_ram;
    ram_wr = is_wr && in_ram;
  end
endmodule

// File: rtl/read_return.sv
module read_return #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_rd,
  input  logic              rom_rd,
  input  logic [DATA_W-1:0] ram_data,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  import boot_pmem_pkg::*;

  rd_src_e src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
    end else if (rom_rd) begin
      src_q <= SRC_ROM;
    end else if (ram_rd) begin
      src_q <= SRC_RAM;
    end else begin
      src_q <= SRC_NONE;
    end
  end

  always_comb begin
    rvalid = (src_q != SRC_NONE);
    unique case (src_q)
      SRC_ROM: rdata = rom_data;
      SRC_RAM: rdata = ram_data;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/boot_pmem_mapper.sv
module boot_pmem_mapper #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 24,
  parameter int RAM_DEPTH   = 512,
  parameter int ROM_DEPTH   = 32,
  parameter int MODE_W      = 2,
  parameter int DELAY_SLOTS = 2,
  parameter int RAM_AW      = $clog2(RAM_DEPTH),
  parameter int ROM_AW      = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              mode_wr_en,
  input  logic [MODE_W-1:0] mode_wr_data,
  input  logic              slot_tick,
  input  logic              p_valid,
  input  logic              p_write,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              p_rvalid,
  output logic [DATA_W-1:0] p_rdata,
  output logic              boot_active,
  output logic [MODE_W-1:0] mode_cur
);
  import boot_pmem_pkg::*;

  localparam logic [MODE_W-1:0] BOOT_CODE = MODE_W'(BOOT_MODE);

  mode_sequencer #(
    .MODE_W     (MODE_W),
    .DELAY_SLOTS(DELAY_SLOTS)
  ) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_pins(mode_pins),
    .wr_en    (mode_wr_en),
    .wr_data  (mode_wr_data),
    .tick     (slot_tick),
    .mode_q   (mode_cur)
  );

  assign boot_active = (mode_cur == BOOT_CODE);

  access_steer #(
    .ADDR_W   (ADDR_W),
    .RAM_DEPTH(RAM_DEPTH),
    .ROM_DEPTH(ROM_DEPTH)
  ) u_steer (
    .boot     (boot_active),
    .req_valid(p_valid),
    .req_write(p_write),
    .req_addr (p_addr),
    .ram_rd   (ram_rd_en),
    .ram_wr   (ram_wr_en),
    .ram_a    (ram_addr),
    .rom_rd   (rom_rd_en),
    .rom_a    (rom_addr)
  );

  read_return #(
    .DATA_W(DATA_W)
  ) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .ram_rd  (ram_rd_en),
    .rom_rd  (rom_rd_en),
    .ram_data(ram_rdata),
    .rom_data(rom_rdata),
    .rvalid  (p_rvalid),
    .rdata   (p_rdata)
  );
endmodule

// File: rtl/boot_pmem_mapper_chk.sv
module boot_pmem_mapper_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr_en,
  input logic              slot_tick,
  input logic              p_valid,
  input logic              p_write,
  input logic              ram_rd_en,
  input logic              ram_wr_en,
  input logic              rom_rd_en,
  input logic              p_rvalid,
  input logic              boot_active,
  input logic [MODE_W-1:0] mode_cur
);
  AST_ROM_ONLY_IN_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |-> boot_active); // R4
  AST_BOOT_READ_HITS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && p_valid && !p_write) |-> (rom_rd_en && !ram_rd_en)); // R2
  AST_MODE_WAITS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> $stable(mode_cur)); // R6
  AST_TICK_WITH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_en && slot_tick) |=> $stable(mode_cur)); // R8
  AST_MODE_MOVES_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(mode_cur)); // R6
  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_rd_en, ram_wr_en, rom_rd_en})); // R10
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en || rom_rd_en) |=> p_rvalid); // R11
endmodule

bind boot_pmem_mapper boot_pmem_mapper_chk #(.MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_wr_en (mode_wr_en),
  .slot_tick  (slot_tick),
  .p_valid    (p_valid),
  .p_write    (p_write),
  .ram_rd_en  (ram_rd_en),
  .ram_wr_en  (ram_wr_en),
  .rom_rd_en  (rom_rd_en),
  .p_rvalid   (p_rvalid),
  .boot_active(boot_active),
  .mode_cur   (mode_cur)
);

// File: tb/boot_pmem_mapper_test.sv
`timescale 1ns/1ps
module boot_pmem_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_pins = 2'd1;
  logic        mode_wr_en = 1'b0;
  logic [1:0]  mode_wr_data = 2'd0;
  logic        slot_tick = 1'b0;
  logic        p_valid = 1'b0;
  logic        p_write = 1'b0;
  logic [15:0] p_addr = '0;
  logic [23:0] rom_rdata = '0;
  logic [23:0] ram_rdata = '0;
  logic        ram_rd_en, ram_wr_en, rom_rd_en, p_rvalid, boot_active;
  logic [8:0]  ram_addr;
  logic [4:0]  rom_addr;
  logic [23:0] p_rdata;
  logic [1:0]  mode_cur;

  int checks = 0;
  int failures = 0;

  // Requirement model state
  logic [1:0] m_mode = 2'd0;
  logic [1:0] m_pend = 2'd0;
  int         m_cnt  = 0;
  int         m_src  = 0; // 0 none, 1 ram, 2 rom

  always #2.5 clk = ~clk;

  boot_pmem_mapper uut (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .mode_wr_en(mode_wr_en),
    .mode_wr_data(mode_wr_data), .slot_tick(slot_tick), .p_valid(p_valid),
    .p_write(p_write), .p_addr(p_addr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
    .rom_rd_en(rom_rd_en), .rom_addr(rom_addr), .p_rvalid(p_rvalid),
    .p_rdata(p_rdata), .boot_active(boot_active), .mode_cur(mode_cur)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit f_boot(input logic [1:0] m);
    return m == 2'd1;
  endfunction
  function automatic bit f_rom_rd(input logic [1:0] m, input bit v, input bit w);
    return f_boot(m) && v && !w;
  endfunction
  function automatic bit f_ram_rd(input logic [1:0] m, input bit v, input bit w, input logic [15:0] a);
    return !f_boot(m) && v && !w && (a < 16'd512);
  endfunction
  function automatic bit f_ram_wr(input bit v, input bit w, input logic [15:0] a);
    return v && w && (a < 16'd512);
  endfunction

  // Drive one cycle (called just after a falling edge), check, then advance the model.
  task automatic step(input bit v, input bit w, input logic [15:0] a,
                      input bit mw, input logic [1:0] md, input bit tk, input string mtag);
    bit er, ew, eo;
    p_valid = v; p_write = w; p_addr = a;
    mode_wr_en = mw; mode_wr_data = md; slot_tick = tk;
    rom_rdata = 24'($urandom); ram_rdata = 24'($urandom);
    #1;
    er = f_ram_rd(m_mode, v, w, a);
    ew = f_ram_wr(v, w, a);
    eo = f_rom_rd(m_mode, v, w);
    chk(mode_cur == m_mode, mtag, mode_cur, m_mode);
    chk(boot_active == f_boot(m_mode), "R9", boot_active, f_boot(m_mode));
    chk(rom_rd_en == eo, "R2", rom_rd_en, eo);
    if (eo) chk(rom_addr == a[4:0], "R2", rom_addr, a[4:0]);
    chk(ram_rd_en == er, (a >= 16'd512) ? "R5" : "R4", ram_rd_en, er);
    chk(ram_wr_en == ew, (a >= 16'd512) ? "R5" : "R3", ram_wr_en, ew);
    if (er || ew) chk(ram_addr == a[8:0], "R3", ram_addr, a[8:0]);
    chk(32'(ram_rd_en) + 32'(ram_wr_en) + 32'(rom_rd_en) <= 1, "R10",
        {ram_rd_en, ram_wr_en, rom_rd_en}, 0);
    chk(p_rvalid == (m_src != 0), "R11", p_rvalid, m_src != 0);
    chk(p_rdata == ((m_src == 2) ? rom_rdata : (m_src == 1) ? ram_rdata : 24'd0),
        "R11", p_rdata, (m_src == 2) ? rom_rdata : (m_src == 1) ? ram_rdata : 24'd0);
    @(posedge clk);
    m_src = eo ? 2 : (er ? 1 : 0);
    if (mw) begin
      m_pend = md; m_cnt = 2;
    end else if (tk && m_cnt != 0) begin
      m_cnt--;
      if (m_cnt == 0) m_mode = m_pend;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] pins);
    @(negedge clk);
    rst_n = 1'b0; mode_pins = pins;
    p_valid = 0; mode_wr_en = 0; slot_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mode = pins; m_pend = pins; m_cnt = 0; m_src = 0;
  endtask

  task automatic idle(input bit tk, input string tag);
    step(0, 0, 16'd0, 0, 2'd0, tk, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: boot from pins
    do_reset(2'd1);
    idle(0, "R1");
    // R2: boot read aliases high address into ROM
    step(1, 0, 16'h1234, 0, 2'd0, 0, "R2");
    step(1, 0, 16'hC000, 0, 2'd0, 0, "R2");
    // R3: boot write to RAM at top word, R5 above range
    step(1, 1, 16'h01FF, 0, 2'd0, 0, "R3");
    step(1, 1, 16'h0200, 0, 2'd0, 0, "R5");
    // R6/R9: leave boot with mode 2, two ticks, read issued in last boot cycle
    step(0, 0, 16'd0, 1, 2'd2, 0, "R6");
    idle(1, "R6");
    step(1, 0, 16'h0007, 0, 2'd0, 1, "R6");
    step(1, 0, 16'h0007, 0, 2'd0, 0, "R9");
    step(1, 0, 16'h0300, 0, 2'd0, 0, "R5");
    // R1: reset into normal mode 0
    do_reset(2'd0);
    idle(0, "R1");
    step(1, 0, 16'h0010, 0, 2'd0, 0, "R4");
    // R7: write 1, tick, write 2 restarts; pending 1 never applied
    step(0, 0, 16'd0, 1, 2'd1, 0, "R7");
    idle(1, "R7");
    step(0, 0, 16'd0, 1, 2'd2, 0, "R7");
    idle(1, "R7");
    idle(1, "R7");
    idle(0, "R7");
    // R8: write with tick in the same cycle, then one tick is not enough
    step(0, 0, 16'd0, 1, 2'd1, 1, "R8");
    idle(1, "R8");
    idle(0, "R8");
    idle(1, "R8");
    // R9: reboot applied, ROM serves reads again
    step(1, 0, 16'h0021, 0, 2'd0, 0, "R9");
    idle(0, "R9");
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 600);
      step(($urandom % 4) != 0, ($urandom % 2) == 1, a,
           ($urandom % 12) == 0, 2'($urandom % 3), ($urandom % 3) == 0, "R6");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule